// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Cycle Controller

This block sequences accesses to a registered-input, registered-output synchronous SRAM. The words are 36 bits wide, in four 9-bit byte lanes. On every rising clock edge it samples two active-low address strobes, three chip enables, an advance input, a global write, a lane-write enable and four lane selects. From these it decides whether the cycle reads, writes, continues a burst or deselects the device. The storage is an array inside the block. The data bus is carried as a separate input word, an output word and an output-enable flag, which is gated by an asynchronous active-low output enable.

The two strobes follow different rules. The processor-side strobe has priority. It is blocked by the first chip enable and always opens an access as a read, so a write through it lands on the following cycle. The controller-side strobe can write in the same cycle it loads the address. Burst address arithmetic is outside the block: on a continuing cycle with advance asserted, the block replaces the two low address bits with a value supplied at its port.

Top module: `pipe_sram_ctrl`

## Requirements
- R1: The synchronous active-high reset leaves the block deselected, with `dq_oe` low in the cycle after reset and until an access makes read data ready.
- R2: When both strobes are low in the same cycle, only the processor strobe is acted on. That cycle is a read even if the write inputs are asserted, and the memory is left unchanged.
- R3: While `sel1_n` is high the processor strobe is ignored. If the controller strobe is also high, the cycle continues the current access as though no strobe had been given.
- R4: Chip enables are looked at only in a cycle that loads a new address. The device is selected when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Continuing cycles go ahead whatever levels the enables have.
- R5: A cycle opened by the processor strobe is a read, and its write and advance inputs are ignored. A write presented on the next cycle (no strobe) is stored at the loaded address in that cycle.
- R6: A controller-strobe write stores data at `addr` in the same cycle, and `adv_n` has no effect in that cycle.
- R7: Lane i is `dq` bits [9i+8:9i]. With `all_wr_n` low every lane is written, whatever `lane_wr_n` and `lane_sel_n` are. Otherwise, with `lane_wr_n` low, exactly the lanes whose `lane_sel_n[i]` is 0 are written, and the other lanes keep their contents.
- R8: A cycle is a write only if `all_wr_n` is low, or if `lane_wr_n` is low with at least one `lane_sel_n` bit low. With `lane_wr_n` low and all lane selects high, the cycle is a read.
- R9: Data read by a cycle whose edge is k appears on `dq_out` after edge k+1. `dq_oe` is the registered data-valid flag ANDed with `oe_n` low, and it follows `oe_n` without waiting for a clock.
- R10: In the first cycle of an access that follows a deselected state, `dq_oe` stays low whatever `oe_n` is.
- R11: After an edge that performs a write, or a deselect, `dq_oe` is low at once.
- R12: After a write, `dq_oe` stays low through continuing cycles that carry no strobe and no advance. A new strobe or an advance cycle brings read data back.
- R13: On a continuing cycle with `adv_n` low, the two low address bits are replaced by `next_lo`. With `adv_n` high the address is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| next_lo | input | BURST_W | Low address bits used on an advance cycle |
| cpu_strb_n | input | 1 | Processor-side address strobe, active low |
| ctl_strb_n | input | 1 | Controller-side address strobe, active low |
| sel1_n | input | 1 | Chip enable 1, active low; also blocks the processor strobe |
| sel2 | input | 1 | Chip enable 2, active high |
| sel3_n | input | 1 | Chip enable 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable; low means high impedance |

## Verification
A wrong access state, such as a stale select flag or a missed write classification, reaches the ports within one or two edges. It shows as `dq_oe` rising on a first access, a write or a deselect, or as `dq_oe` staying low when read data should appear. A wrong lane mask or a wrong write address stays hidden until that word is read back, and then shows two edges after the read's address edge as the wrong lane contents on `dq_out`. For this reason every write in the stimulus is followed by a read-back. A write that the strobe rules should have suppressed is caught by reading the word back, which still holds its earlier value.

// File: rtl/psc_pkg.sv
package psc_pkg;
  // kind of cycle decided at a clock edge
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,  // deselected / no device activity
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/psc_decode.sv
module psc_decode
  import psc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cpu_strb_n,
  input  logic             ctl_strb_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             adv_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             active,
  input  logic             quiet,
  input  logic             block,
  output logic             load,
  output logic             advance,
  output logic             fresh,
  output cyc_e             kind,
  output logic [LANES-1:0] lane_we
);
  logic             p_take;
  logic             c_take;
  logic             chip_on;
  logic             wr_req;
  logic [LANES-1:0] req_lanes;

  always_comb begin
    // processor strobe is blocked by enable 1 and has priority
    p_take  = !cpu_strb_n && !sel1_n;
    c_take  = !p_take && !ctl_strb_n;
    load    = p_take || c_take;
    chip_on = !sel1_n && sel2 && !sel3_n;

    // global write covers every lane; otherwise lane enable + selects
    if (!all_wr_n)      req_lanes = '1;
    else if (!lane_wr_n) req_lanes = ~lane_sel_n;
    else                req_lanes = '0;
    wr_req = |req_lanes;

    if (block)        kind = CYC_IDLE;
    else if (load) begin
      if (!chip_on)    kind = CYC_IDLE;
      else if (p_take) kind = CYC_READ;   // processor start is always a read
      else             kind = wr_req ? CYC_WRITE : CYC_READ;
    end
    else if (!active) kind = CYC_IDLE;
    else              kind = wr_req ? CYC_WRITE : CYC_READ;

    advance = !block && !load && active && !adv_n;
    fresh   = load || advance || !quiet;
    lane_we = (kind == CYC_WRITE) ? req_lanes : '0;
  end
endmodule

// File: rtl/psc_addr.sv
module psc_addr #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BURST_W-1:0] next_lo,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  always_comb begin
    if (load)         nxt_addr = addr_in;
    else if (advance) nxt_addr = {cur_addr[ADDR_W-1 -: HI_W], next_lo};
    else              nxt_addr = cur_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) cur_addr <= '0;
    else     cur_addr <= nxt_addr;
  end
endmodule

// File: rtl/psc_array.sv
module psc_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // one simple dual-port memory per lane so each maps to block RAM
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      rd_q <= mem[raddr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import psc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BURST_W-1:0]      next_lo,
  input  logic                    cpu_strb_n,
  input  logic                    ctl_strb_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    adv_n,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic              active_q;     // an access is open (device selected)
  logic              quiet_q;      // bus held off since the last write
  logic              rd_pend_q;    // previous edge read data that may be shown
  logic              out_valid_q;  // dq_out holds data to drive
  logic              load;
  logic              advance;
  logic              fresh;
  cyc_e              kind;
  logic [LANES-1:0]  wr_lanes;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] rdata;

  psc_decode #(.LANES(LANES)) u_decode (
    .cpu_strb_n (cpu_strb_n),
    .ctl_strb_n (ctl_strb_n),
    .sel1_n     (sel1_n),
    .sel2       (sel2),
    .sel3_n     (sel3_n),
    .adv_n      (adv_n),
    .all_wr_n   (all_wr_n),
    .lane_wr_n  (lane_wr_n),
    .lane_sel_n (lane_sel_n),
    .active     (active_q),
    .quiet      (quiet_q),
    .block      (rst),
    .load       (load),
    .advance    (advance),
    .fresh      (fresh),
    .kind       (kind),
    .lane_we    (wr_lanes)
  );

  psc_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .advance  (advance),
    .addr_in  (addr),
    .next_lo  (next_lo),
    .cur_addr (cur_addr),
    .nxt_addr (nxt_addr)
  );

  // writes land at this cycle's address; reads use the address
  // registered on the previous edge, giving one extra output stage
  psc_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (wr_lanes),
    .waddr (nxt_addr),
    .wdata (dq_in),
    .raddr (cur_addr),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q    <= 1'b0;
      quiet_q     <= 1'b0;
      rd_pend_q   <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      active_q    <= (kind != CYC_IDLE);
      if (kind == CYC_WRITE)    quiet_q <= 1'b1;
      else if (load || advance) quiet_q <= 1'b0;
      rd_pend_q   <= (kind == CYC_READ) && fresh;
      // write or deselect at this edge turns the bus off right away
      out_valid_q <= (kind == CYC_READ) && rd_pend_q;
    end
  end

  assign dq_out = rdata;
  assign dq_oe  = out_valid_q && !oe_n;
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_strb_n,
  input logic             ctl_strb_n,
  input logic             sel1_n,
  input logic             sel2,
  input logic             sel3_n,
  input logic             all_wr_n,
  input logic             lane_wr_n,
  input logic [LANES-1:0] lane_sel_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic             active_q,
  input logic [LANES-1:0] wr_lanes
);
  logic chip_on;
  logic any_load;
  logic wr_inputs;

  assign chip_on   = !sel1_n && sel2 && !sel3_n;
  assign any_load  = (!cpu_strb_n && !sel1_n) || !ctl_strb_n;
  assign wr_inputs = !all_wr_n || (!lane_wr_n && !(&lane_sel_n));

  // R1: bus is off in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dq_oe);

  // R2, R5: a processor-strobe start never writes memory
  a_r2_proc_no_write: assert property (@(posedge clk) disable iff (rst)
    (!cpu_strb_n && !sel1_n) |-> (wr_lanes == '0));

  // R9: output enable high always tri-states the bus
  a_r9_oe_gate: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);

  // R10: first access after deselect keeps the bus off
  a_r10_first_quiet: assert property (@(posedge clk) disable iff (rst)
    (!active_q && any_load && chip_on) |=> !dq_oe);

  // R11: a controller-strobe write turns the bus off
  a_r11_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (cpu_strb_n && !ctl_strb_n && chip_on && wr_inputs) |=> !dq_oe);

  // R11: a load without selection turns the bus off
  a_r11_desel_quiet: assert property (@(posedge clk) disable iff (rst)
    (any_load && !chip_on) |=> !dq_oe);
endmodule

bind pipe_sram_ctrl psc_checker #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_strb_n (cpu_strb_n),
  .ctl_strb_n (ctl_strb_n),
  .sel1_n     (sel1_n),
  .sel2       (sel2),
  .sel3_n     (sel3_n),
  .all_wr_n   (all_wr_n),
  .lane_wr_n  (lane_wr_n),
  .lane_sel_n (lane_sel_n),
  .oe_n       (oe_n),
  .dq_oe      (dq_oe),
  .active_q   (active_q),
  .wr_lanes   (wr_lanes)
);

// File: tb/test_pipe_sram_ctrl.sv
module test_pipe_sram_ctrl;
  localparam logic H = 1'b1;
  localparam logic L = 1'b0;
  localparam logic [35:0] Z  = 36'h0;
  localparam logic [35:0] DA = {9'h101, 9'h102, 9'h103, 9'h104};
  localparam logic [35:0] DB = {9'h055, 9'h066, 9'h077, 9'h088};
  localparam logic [35:0] DF = {9'h1F3, 9'h1F2, 9'h1F1, 9'h1F0};
  // DF written with lane selects 4'b0101: lanes 3 and 1 from DF, 2 and 0 kept from DA
  localparam logic [35:0] DM = {9'h1F3, 9'h102, 9'h1F1, 9'h104};
  localparam logic [35:0] DU = 36'h3C3C3C3C3;
  localparam logic [35:0] DV = 36'h5A5A5A5A5;

  typedef struct packed {
    logic        cpu_n, ctl_n, s1n, s2, s3n, adv_n, gw_n, bwe_n;
    logic [3:0]  bsel;
    logic [1:0]  nlo;
    logic        oe_n;
    logic [7:0]  addr;
    logic [35:0] din;
    logic        e_oe;
    logic [35:0] e_dat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  // cpu ctl s1n s2 s3n adv gw bwe bsel nlo oe addr din | exp_oe exp_dat req
  localparam vec_t VECS [NV] = '{
    '{H,L,L,H,L,H,L,H,4'hF,2'd0,L,8'h10,DA, L,Z, 4'd6},  // R6 controller write
    '{H,L,L,H,L,H,L,H,4'hF,2'd0,L,8'h11,DB, L,Z, 4'd6},  // R6
    '{H,L,L,H,L,H,H,H,4'hF,2'd0,L,8'h10,Z,  L,Z, 4'd9},  // R9 read registered, no data yet
    '{H,L,L,H,L,H,H,H,4'hF,2'd0,L,8'h11,Z,  H,DA,4'd9},  // R9 data of 0x10
    '{H,H,H,L,H,L,H,H,4'hF,2'd0,L,8'h00,Z,  H,DB,4'd4},  // R4 advance with enables off
    '{H,H,H,L,H,H,H,H,4'hF,2'd0,L,8'h00,Z,  H,DA,4'd13}, // R13 advanced to 0x10
    '{H,H,H,L,H,H,H,H,4'hF,2'd0,H,8'h00,Z,  L,Z, 4'd9},  // R9 oe_n high
    '{L,H,H,H,L,H,H,H,4'hF,2'd0,L,8'h11,Z,  H,DA,4'd3},  // R3 blocked processor strobe
    '{H,L,L,H,L,H,H,L,4'h5,2'd0,L,8'h10,DF, L,Z, 4'd7},  // R7 lane write, R11 bus off
    '{H,L,L,H,L,H,H,L,4'hF,2'd0,L,8'h10,DF, L,Z, 4'd8},  // R8 no lane selected -> read
    '{H,H,H,L,H,H,H,H,4'hF,2'd0,L,8'h00,Z,  H,DM,4'd8},  // R8 R7 merged lanes
    '{L,L,L,H,L,H,L,H,4'hF,2'd0,L,8'h11,Z,  H,DM,4'd2},  // R2 both strobes, write inputs on
    '{H,H,H,L,H,H,H,H,4'hF,2'd0,L,8'h00,Z,  H,DB,4'd2},  // R2 0x11 unchanged
    '{H,L,L,L,L,H,H,H,4'hF,2'd0,L,8'h00,Z,  L,Z, 4'd11}  // R11 deselect
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  addr;
  logic [1:0]  next_lo;
  logic        cpu_strb_n, ctl_strb_n, sel1_n, sel2, sel3_n, adv_n;
  logic        all_wr_n, lane_wr_n, oe_n;
  logic [3:0]  lane_sel_n;
  logic [35:0] dq_in;
  logic [35:0] dq_out;
  logic        dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pipe_sram_ctrl i_pipe_sram_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .next_lo(next_lo),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .adv_n(adv_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic vec_t f_idle();
    vec_t v;
    v = '0;
    v.cpu_n = H; v.ctl_n = H; v.s1n = H; v.s3n = H;
    v.adv_n = H; v.gw_n = H; v.bwe_n = H; v.bsel = 4'hF;
    return v;
  endfunction

  function automatic vec_t f_ctl(logic [7:0] a, logic gw, logic [35:0] d);
    vec_t v;
    v = f_idle();
    v.ctl_n = L; v.s1n = L; v.s2 = H; v.s3n = L;
    v.gw_n = gw; v.addr = a; v.din = d;
    return v;
  endfunction

  task automatic put(input vec_t v);
    cpu_strb_n = v.cpu_n; ctl_strb_n = v.ctl_n;
    sel1_n = v.s1n; sel2 = v.s2; sel3_n = v.s3n; adv_n = v.adv_n;
    all_wr_n = v.gw_n; lane_wr_n = v.bwe_n; lane_sel_n = v.bsel;
    next_lo = v.nlo; oe_n = v.oe_n; addr = v.addr; dq_in = v.din;
  endtask

  // drive away from the active edge, then sample 2 ns after it
  task automatic step(input vec_t v);
    @(negedge clk);
    put(v);
    @(posedge clk);
    #2;
  endtask

  task automatic check_out(input int req, input logic eoe, input logic [35:0] edat);
    checks++;
    if (dq_oe !== eoe || (eoe && dq_out !== edat)) begin
      errors++;
      $display("FAIL R%0d: dq_oe=%b dq_out=%h expected dq_oe=%b dq_out=%h",
               req, dq_oe, dq_out, eoe, edat);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    rst = 1'b1;
    put(f_idle());
    repeat (3) @(posedge clk);
    #2;
    check_out(1, L, Z);  // R1 during reset
    @(negedge clk);
    rst = 1'b0;
    step(f_idle());
    check_out(1, L, Z);  // R1 after reset

    for (int i = 0; i < NV; i++) begin
      step(VECS[i]);
      check_out(int'(VECS[i].req), VECS[i].e_oe, VECS[i].e_dat);
    end

    // R10: first access after the deselect above keeps the bus off
    step(f_ctl(8'h11, H, Z));
    check_out(10, L, Z);
    step(f_idle());
    check_out(10, H, DB);

    // R6: controller write ignores advance; R13 advance replaces low bits
    step(f_ctl(8'h27, L, DV));
    v = f_ctl(8'h24, L, DU); v.adv_n = L; v.nlo = 2'd3;
    step(v);
    check_out(6, L, Z);
    step(f_ctl(8'h24, H, Z));
    step(f_idle());
    check_out(6, H, DU);
    v = f_idle(); v.adv_n = L; v.nlo = 2'd3;
    step(v);
    check_out(13, H, DU);
    step(f_idle());
    check_out(13, H, DV);   // R13 0x27, also R6 untouched by the 0x24 write

    // R5: processor start is a read, write lands on the next cycle
    step(f_ctl(8'h20, L, DA));
    v = f_ctl(8'h20, L, DB); v.ctl_n = H; v.cpu_n = L; v.adv_n = L; v.nlo = 2'd3;
    step(v);
    check_out(5, L, Z);
    step(f_idle());
    check_out(5, H, DA);
    v = f_idle(); v.gw_n = L; v.din = DF;
    step(v);
    check_out(11, L, Z);    // R11 write turns bus off
    step(f_idle());
    check_out(12, L, Z);    // R12 hold after write
    step(f_idle());
    check_out(12, L, Z);    // R12 still off
    v = f_idle(); v.adv_n = L; v.nlo = 2'd0;
    step(v);
    step(f_idle());
    check_out(5, H, DF);    // R5 second-cycle write stored, R12 advance resumes

    // R9: output enable acts without a clock
    oe_n = H;
    #1;
    check_out(9, L, Z);
    oe_n = L;
    #1;
    check_out(9, H, DF);

    // R1: reset in mid-run drops the bus
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    @(negedge clk);
    rst = 1'b0;
    step(f_idle());
    check_out(1, L, Z);

    // R7: global write overrides lane selects
    v = f_ctl(8'h10, L, DB); v.bwe_n = L; v.bsel = 4'b1110;
    step(v);
    step(f_ctl(8'h10, H, Z));
    step(f_idle());
    check_out(7, H, DB);

    // R3: controller load while enable 1 is high deselects
    v = f_ctl(8'h10, H, Z); v.cpu_n = L; v.s1n = H;
    step(v);
    check_out(3, L, Z);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule